// File: doc/BRIEF.md
# Transaction Retry Policy Controller

This block is a per-thread sequencer for a best-effort hardware transaction engine. For each critical section it decides when to begin a transaction. After each abort it decides whether to run the transaction again or to give up and take the global lock. It watches the begin, commit and abort events, the abort hint that marks an abort as persistent, a capacity-overflow flag, and the state of the global lock word. It drives the commands to wait for the lock, to begin, to force an abort, to end, to acquire the lock and to release it.

Each abort falls into one of three classes, and each class has its own retry budget. Aborts seen while the lock word is held are lock conflicts. Aborts with the persistent hint or the capacity flag are persistent. All other aborts are transient. The three budgets are loaded from three programmable maxima each time a section starts. At the end of every section the controller reports whether the section finished by a commit or under the lock, so a serialization ratio can be counted outside the block.

Top module: `txn_retry_ctrl`

## Requirements
- R1: After reset the controller is idle: every command output is 0 and `sec_done` is 0.
- R2: While idle, a `sec_start` pulse loads the three budgets from `max_lock_retry`, `max_pers_retry` and `max_trans_retry`. Before every begin, the controller raises `wait_lock` and holds `tx_begin` low for as long as `lock_held` is 1. In any other state, `sec_start` is ignored.
- R3: In the cycle right after `tx_begin`, `tx_force_abort` is 1 exactly when `lock_held` is 1.
- R4: An abort that arrives while `lock_held` is 1 is charged to the lock budget. With a lock maximum of M, M begins occur before the lock is requested, provided every abort is of this class.
- R5: An abort with `abort_persistent` = 1, or with `abort_capacity` = 1 (even when the hint is 0), and with the lock free, is charged to the persistent budget.
- R6: Any other abort is charged to the transient budget.
- R7: On an abort, the charged budget is decremented. If the value before the decrement is above 1, the controller returns to waiting for the lock and begins again. Otherwise it raises `lock_acquire`. A maximum of 1 or 0 therefore allows no retry.
- R8: Once `lock_granted` has arrived, `body_done` causes a one-cycle `lock_release`. In the following cycle `sec_done` = 1 with `sec_by_lock` = 1.
- R9: On the transactional path, `body_done` raises `tx_end`, which stays high until `tx_committed`. One cycle later `sec_done` = 1 with `sec_by_lock` = 0. An abort while `tx_end` is high is handled as in R4 to R7.
- R10: Each budget is consumed only by aborts of its own class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_start | input | 1 | Pulse: a new critical section begins |
| max_lock_retry | input | CNT_W | Lock-conflict budget maximum |
| max_pers_retry | input | CNT_W | Persistent budget maximum |
| max_trans_retry | input | CNT_W | Transient budget maximum |
| lock_held | input | 1 | Current state of the global lock word |
| lock_granted | input | 1 | Lock acquisition completed |
| tx_aborted | input | 1 | Abort event of the running transaction |
| abort_persistent | input | 1 | Abort reason hint: persistent |
| abort_capacity | input | 1 | Abort reason: capacity overflow |
| tx_committed | input | 1 | Commit event |
| body_done | input | 1 | Section body has finished |
| wait_lock | output | 1 | Waiting for the lock to become free |
| tx_begin | output | 1 | Begin a transaction |
| tx_force_abort | output | 1 | Force the fresh transaction to abort |
| tx_end | output | 1 | End the transaction |
| lock_acquire | output | 1 | Request the global lock |
| lock_release | output | 1 | Release the global lock |
| sec_done | output | 1 | Pulse: section finished |
| sec_by_lock | output | 1 | Last finished section ran under the lock |

## Verification
The subscription check and the abort classification can fall in the same cycle. The cycle after a begin may see the lock held, which raises a forced abort, and also a real abort, which must be classed as a lock conflict in that same cycle. The bench provokes this by raising `lock_held` and `tx_aborted` together in that cycle. It then judges the outcome by the begin count up to `lock_acquire` and by `tx_force_abort` in that cycle. A commit attempt that aborts while `tx_end` is high is also driven, to show that the abort path takes precedence over completion.

// File: rtl/trc_pkg.sv
// Shared types of the transaction retry controller.
// Assumes: exactly three abort classes, indexed as below.
package trc_pkg;
    localparam int NUM_CLASS = 3;
    localparam int CLS_LOCK  = 0;
    localparam int CLS_PERS  = 1;
    localparam int CLS_TRANS = 2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_BEGIN, ST_CHECK, ST_RUN,
        ST_END, ST_ACQ, ST_LOCKED, ST_REL
    } trc_state_e;
endpackage

// File: rtl/trc_classify.sv
// Abort classifier: maps the abort context onto one of three budget classes.
// Assumes: inputs are sampled in the cycle of the abort event; lock conflict
// takes priority over the reason hint, capacity overflow counts as persistent.
module trc_classify
    import trc_pkg::*;
(
    input  logic                 lock_held,
    input  logic                 abort_persistent,
    input  logic                 abort_capacity,
    output logic [NUM_CLASS-1:0] cls_onehot
);
    // Priority decode of the abort class.
    always_comb begin
        cls_onehot = '0;
        if (lock_held)
            cls_onehot[CLS_LOCK] = 1'b1;
        else if (abort_persistent || abort_capacity)
            cls_onehot[CLS_PERS] = 1'b1;
        else
            cls_onehot[CLS_TRANS] = 1'b1;
    end
endmodule

// File: rtl/trc_budget.sv
// One retry budget: loaded with a maximum, decremented on each charged abort.
// Assumes: load and dec never coincide; decrement saturates at zero.
module trc_budget #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] max_val,
    input  logic             dec,
    output logic             has_retry
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Budget register: load, saturating decrement, hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= max_val;
        else if (dec && cnt != '0)
            cnt <= cnt - ONE;
    end

    // A retry remains if the decremented value would still be above zero.
    assign has_retry = (cnt > ONE);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt == '0) |=> cnt == '0);                         // R7
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(max_val));                                     // R2
endmodule

// File: rtl/txn_retry_ctrl.sv
// Transaction retry policy controller (top).
// Sequences one critical section: wait for free lock, begin, check the lock
// word, classify aborts into three budgets, retry or fall back to the lock,
// and finish by commit or by release. Assumes the environment answers
// tx_begin with either body_done or tx_aborted, and lock_acquire with
// lock_granted.
module txn_retry_ctrl
    import trc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_start,
    input  logic [CNT_W-1:0] max_lock_retry,
    input  logic [CNT_W-1:0] max_pers_retry,
    input  logic [CNT_W-1:0] max_trans_retry,
    input  logic             lock_held,
    input  logic             lock_granted,
    input  logic             tx_aborted,
    input  logic             abort_persistent,
    input  logic             abort_capacity,
    input  logic             tx_committed,
    input  logic             body_done,
    output logic             wait_lock,
    output logic             tx_begin,
    output logic             tx_force_abort,
    output logic             tx_end,
    output logic             lock_acquire,
    output logic             lock_release,
    output logic             sec_done,
    output logic             sec_by_lock
);
    trc_state_e             st, st_nxt;
    logic                   load_all;
    logic                   abort_evt;
    logic                   done_set, done_lock;
    logic [NUM_CLASS-1:0]   cls;
    logic [NUM_CLASS-1:0]   has_retry;
    logic [NUM_CLASS-1:0][CNT_W-1:0] max_arr;
    logic                   retry_ok;
    logic                   in_tx;

    assign max_arr[CLS_LOCK]  = max_lock_retry;
    assign max_arr[CLS_PERS]  = max_pers_retry;
    assign max_arr[CLS_TRANS] = max_trans_retry;

    trc_classify u_cls (
        .lock_held        (lock_held),
        .abort_persistent (abort_persistent),
        .abort_capacity   (abort_capacity),
        .cls_onehot       (cls)
    );

    // One budget per abort class.
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_budget
        trc_budget #(.CNT_W(CNT_W)) u_bud (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_all),
            .max_val   (max_arr[g]),
            .dec       (abort_evt && cls[g]),
            .has_retry (has_retry[g])
        );
    end

    assign retry_ok = |(cls & has_retry);
    assign in_tx    = (st == ST_CHECK) || (st == ST_RUN) || (st == ST_END);

    // Next-state and event decode of the section sequencer.
    always_comb begin
        st_nxt    = st;
        load_all  = 1'b0;
        abort_evt = 1'b0;
        done_set  = 1'b0;
        done_lock = 1'b0;
        case (st)
            ST_IDLE:   if (sec_start) begin
                           load_all = 1'b1;
                           st_nxt   = ST_WAIT;
                       end
            ST_WAIT:   if (!lock_held) st_nxt = ST_BEGIN;
            ST_BEGIN:  st_nxt = ST_CHECK;
            ST_CHECK, ST_RUN, ST_END: begin
                if (tx_aborted) begin
                    abort_evt = 1'b1;
                    st_nxt    = retry_ok ? ST_WAIT : ST_ACQ;
                end else if (st == ST_END) begin
                    if (tx_committed) begin
                        done_set = 1'b1;
                        st_nxt   = ST_IDLE;
                    end
                end else if (st == ST_CHECK && lock_held) begin
                    st_nxt = ST_RUN;
                end else if (body_done) begin
                    st_nxt = ST_END;
                end else begin
                    st_nxt = ST_RUN;
                end
            end
            ST_ACQ:    if (lock_granted) st_nxt = ST_LOCKED;
            ST_LOCKED: if (body_done) st_nxt = ST_REL;
            ST_REL: begin
                done_set  = 1'b1;
                done_lock = 1'b1;
                st_nxt    = ST_IDLE;
            end
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Section completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_done    <= 1'b0;
            sec_by_lock <= 1'b0;
        end else begin
            sec_done <= done_set;
            if (done_set) sec_by_lock <= done_lock;
        end
    end

    // Command outputs decoded from state.
    assign wait_lock      = (st == ST_WAIT);
    assign tx_begin       = (st == ST_BEGIN);
    assign tx_force_abort = (st == ST_CHECK) && lock_held;
    assign tx_end         = (st == ST_END);
    assign lock_acquire   = (st == ST_ACQ);
    assign lock_release   = (st == ST_REL);

    AST_BEGIN_LOCK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_begin |-> !$past(lock_held));                                     // R2
    AST_FORCE_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_begin) && lock_held) |-> tx_force_abort);                  // R3
    AST_ACQ_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_acquire) |-> $past(tx_aborted) && $past(in_tx));          // R7
    AST_RELEASE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_release |=> sec_done && sec_by_lock);                           // R8
    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !tx_committed && !tx_aborted) |=> tx_end);                // R9
    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wait_lock, tx_begin, tx_end, lock_acquire, lock_release})); // R1
endmodule

// File: tb/sim_txn_retry_ctrl.sv
module sim_txn_retry_ctrl;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_start = 0, lock_held = 0, lock_granted = 0, tx_aborted = 0;
    logic abort_persistent = 0, abort_capacity = 0, tx_committed = 0, body_done = 0;
    logic [CNT_W-1:0] max_lock_retry = 0, max_pers_retry = 0, max_trans_retry = 0;
    logic wait_lock, tx_begin, tx_force_abort, tx_end, lock_acquire, lock_release;
    logic sec_done, sec_by_lock;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txn_retry_ctrl #(.CNT_W(CNT_W)) u0 (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic start_sec(input int ml, input int mp, input int mt);
        max_lock_retry  = CNT_W'(ml);
        max_pers_retry  = CNT_W'(mp);
        max_trans_retry = CNT_W'(mt);
        sec_start = 1;
        tick();
        sec_start = 0;
    endtask

    // Wait (lock free) for the begin pulse; returns 1 if seen.
    task automatic await_begin(output bit seen);
        seen = 0;
        lock_held = 0;
        for (int i = 0; i < 4; i++) begin
            if (tx_begin) begin seen = 1; break; end
            tick();
        end
    endtask

    // One attempt: begin, then abort in the check cycle with given context.
    task automatic attempt(input logic lk, input logic ps, input logic cap,
                           output bit acq, output bit begun);
        await_begin(begun);
        tick();                              // check cycle
        lock_held = lk; abort_persistent = ps; abort_capacity = cap; tx_aborted = 1;
        #1;
        chk(tx_force_abort == lk, "R3 force abort on held lock", tx_force_abort, lk);
        tick();
        tx_aborted = 0; abort_persistent = 0; abort_capacity = 0;
        #1;
        acq = lock_acquire;
        if (!acq && lk) begin
            tick();
            chk(wait_lock && !tx_begin, "R2 no begin while lock held", tx_begin, 0);
        end
        lock_held = 0;
    endtask

    task automatic finish_locked();
        lock_granted = 1; tick(); lock_granted = 0;
        body_done = 1; tick(); body_done = 0;
        chk(lock_release == 1, "R8 release pulse", lock_release, 1);
        tick();
        chk(sec_done && sec_by_lock, "R8 done by lock", {sec_done, sec_by_lock}, 3);
    endtask

    // Run attempts of one kind until lock requested; return begin count.
    task automatic until_acq(input logic lk, input logic ps, input logic cap, output int nb);
        bit acq, bg;
        nb = 0;
        for (int i = 0; i < 20; i++) begin
            attempt(lk, ps, cap, acq, bg);
            if (bg) nb++;
            if (acq) break;
        end
    endtask

    task automatic t_reset();
        chk({wait_lock, tx_begin, tx_force_abort, tx_end, lock_acquire, lock_release, sec_done} == 0,
            "R1 reset idle", {wait_lock, tx_begin, tx_end, lock_acquire}, 0);
        sec_start = 0; tick();
        chk(!wait_lock, "R1 stays idle", wait_lock, 0);
    endtask

    task automatic t_commit();
        bit bg;
        lock_held = 1;
        start_sec(2, 2, 2);
        tick(); tick();
        chk(wait_lock && !tx_begin, "R2 wait while held", tx_begin, 0);
        await_begin(bg);
        chk(bg, "R2 begin once free", bg, 1);
        sec_start = 1;               // ignored outside idle
        tick(); sec_start = 0;
        body_done = 1; tick(); body_done = 0;
        chk(tx_end, "R9 end raised", tx_end, 1);
        tick(); tick();
        chk(tx_end, "R9 end held until commit", tx_end, 1);
        tx_committed = 1; tick(); tx_committed = 0;
        chk(sec_done && !sec_by_lock, "R9 done by commit", {sec_done, sec_by_lock}, 2);
        tick();
        chk(!sec_done && !wait_lock, "R2 start ignored while busy", wait_lock, 0);
    endtask

    task automatic t_lock_class();
        int nb;
        start_sec(3, 1, 1);
        until_acq(1, 0, 0, nb);
        chk(nb == 3, "R4 lock budget begins", nb, 3);
        finish_locked();
    endtask

    task automatic t_pers_class();
        int nb;
        start_sec(1, 4, 1);
        until_acq(0, 1, 0, nb);
        chk(nb == 4, "R5 persistent budget begins", nb, 4);
        finish_locked();
        start_sec(9, 1, 5);
        until_acq(0, 0, 1, nb);
        chk(nb == 1, "R5 capacity counts as persistent", nb, 1);
        finish_locked();
    endtask

    task automatic t_trans_class();
        int nb;
        start_sec(1, 1, 5);
        until_acq(0, 0, 0, nb);
        chk(nb == 5, "R6 transient budget begins", nb, 5);
        finish_locked();
        start_sec(1, 1, 0);
        until_acq(0, 0, 0, nb);
        chk(nb == 1, "R7 max zero gives no retry", nb, 1);
        finish_locked();
    endtask

    task automatic t_independent();
        bit acq, bg;
        int nb = 0;
        start_sec(2, 2, 2);
        attempt(0, 0, 0, acq, bg); nb += int'(bg);
        chk(!acq, "R10 transient retry", acq, 0);
        attempt(0, 1, 0, acq, bg); nb += int'(bg);
        chk(!acq, "R10 persistent untouched by transient", acq, 0);
        attempt(1, 0, 0, acq, bg); nb += int'(bg);
        chk(!acq, "R10 lock untouched by others", acq, 0);
        attempt(0, 0, 0, acq, bg); nb += int'(bg);
        chk(acq && nb == 4, "R7 transient exhausted", nb, 4);
        finish_locked();
    endtask

    task automatic t_abort_at_end();
        bit bg;
        start_sec(1, 1, 2);
        await_begin(bg);
        tick();
        body_done = 1; tick(); body_done = 0;
        tx_aborted = 1; tick(); tx_aborted = 0;
        chk(wait_lock && !sec_done, "R9 abort during end retries", wait_lock, 1);
        await_begin(bg);
        tick();
        tx_aborted = 1; tick(); tx_aborted = 0;
        chk(lock_acquire, "R7 second transient abort acquires", lock_acquire, 1);
        finish_locked();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #1;
        t_reset();
        t_commit();
        t_lock_class();
        t_pers_class();
        t_trans_class();
        t_independent();
        t_abort_at_end();
        repeat (2) tick();
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
            $finish;
        end
    end
endmodule